// File: doc/BRIEF.md
# Cascaded Codec Serial Frame Interpreter

This block sits on the device side of a synchronous serial link that joins a processor to a chain of codecs. It receives 16-bit frames on a serial data line, each framed by a one-cycle frame-sync pulse and clocked by the serial clock. It counts the frame syncs seen since the last sample-period boundary and claims only the frame whose ordinal matches its programmed device position. Depending on the active mode, a claimed frame is a configuration-register write or a sample for the DAC register.

The block keeps a small configuration register bank. Register 0 holds the mode bits, the cascade position and two loop-back enables. In the other direction it serialises the ADC register once per sample period. When serial loop-back is enabled, the output instead reproduces the incoming frame sync and data after a fixed delay. When digital loop-back is enabled, ADC samples feed the DAC register directly. The ADC and DAC are plain parallel words; the serial clock is the block clock.

Top module: `codec_frame_interp`

## Requirements
- R1: After reset, every configuration register is 0, which means program mode, cascade position 1 and both loop-backs off. Also after reset `dac_word` is 0, and `dac_we`, `sdo` and `fs_out` are low.
- R2: A frame is a one-cycle `fs_in` pulse followed by 16 bits on `sdi` sampled MSB first on the next 16 rising edges. The frame's effect (register write or `dac_we` pulse) becomes visible after the rising edge that follows the edge sampling its last bit.
- R3: The block counts `fs_in` pulses since the last `sample_tick`; a tick in the same cycle as a frame sync makes that frame number 1. Register 0 bits [4:2] hold the position minus one. Only the frame whose number equals that field plus one is claimed, and unclaimed frames change nothing.
- R4: When register 0 bits [1:0] are 00 or 10 (program mode), a claimed frame is a register write: bits [14:12] select the register and bits [7:0] give the value. Bit 15 is ignored in this mode.
- R5: When bits [1:0] are 01 (plain data mode), each claimed frame is copied unchanged to `dac_word` with a one-cycle `dac_we`. No frame can change any register in this mode; only reset leaves it.
- R6: When bits [1:0] are 11 (mixed mode), a claimed frame with bit 15 = 1 is a register write laid out as in R4. A claimed frame with bit 15 = 0 loads `dac_word` with bits [14:0] shifted up one place and bit 0 = 0.
- R7: On each `sample_tick`, `fs_out` is high for the cycle after that edge. Then `adc_word` leaves MSB first on `sdo` over the next 16 cycles, and `sdo` is 0 otherwise. In mixed mode the word's MSB is sent as 0.
- R8: With register 0 bit 6 set (serial loop-back), `sdo` and `fs_out` replay `sdi` and `fs_in`. A value sampled at one rising edge appears after the 15th edge following it.
- R9: With register 0 bit 5 set (digital loop-back), each `sample_tick` copies `adc_word` to `dac_word` with a `dac_we` pulse after that edge. Frames carrying DAC data are ignored while it is set.
- R10: The loop-back bits 5 and 6 of register 0 can be cleared only by a write made in mixed mode. A program-mode write can set them but leaves set bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_in | input | 1 | Input frame-sync pulse |
| sdi | input | 1 | Serial data in, MSB first |
| sample_tick | input | 1 | Sample-period boundary strobe |
| adc_word | input | 16 | ADC register contents |
| sdo | output | 1 | Serial data out |
| fs_out | output | 1 | Output frame-sync pulse |
| dac_word | output | 16 | DAC register |
| dac_we | output | 1 | One-cycle DAC update strobe |
| cfg_regs | output | 64 | Configuration bank, register i at bits [8i+7:8i] |

## Verification
The state that is hardest to reach is a loop-back bit that is set and then has to be shown to survive a clearing write. The bench gets there with a program-mode write that sets the bit, then a second program-mode write that tries to clear it. It then moves into mixed mode without clearing the bit and clears it there. Cascade claiming is swept over several positions by first programming the position through a frame claimed at the old one. A final case raises the tick in the same cycle as the frame sync.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
   localparam int BIT_DATA  = 0;
   localparam int BIT_MIXED = 1;
   localparam int DC_LSB    = 2;
   localparam int BIT_DLB   = 5;
   localparam int BIT_SLB   = 6;

   typedef enum logic [1:0] {
      MODE_PGM   = 2'd0,
      MODE_DATA  = 2'd1,
      MODE_MIXED = 2'd2
   } mode_e;

   function automatic mode_e mode_of(input logic dp, input logic mm);
      if (!dp)
         return MODE_PGM;
      return mm ? MODE_MIXED : MODE_DATA;
   endfunction
endpackage

// File: rtl/cfi_rx.sv
module cfi_rx #(
   parameter int FRAME_W = 16,
   parameter int DC_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_in,
   input  logic              sdi,
   input  logic              sample_tick,
   output logic              rx_valid,
   output logic [FRAME_W-1:0] rx_word,
   output logic [DC_W:0]     rx_ord
);
   localparam int BC_W  = $clog2(FRAME_W + 1);
   localparam int ORD_W = DC_W + 1;

   logic [ORD_W-1:0]   fs_cnt, ord_base, ord_next, cur_ord;
   logic [BC_W-1:0]    bit_cnt;
   logic [FRAME_W-1:0] sr;

   always_comb begin
      ord_base = sample_tick ? '0 : fs_cnt;
      ord_next = (ord_base == '1) ? ord_base : ord_base + ORD_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fs_cnt <= '0;
      else if (fs_in)
         fs_cnt <= ord_next;
      else if (sample_tick)
         fs_cnt <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         sr       <= '0;
         cur_ord  <= '0;
         rx_valid <= 1'b0;
         rx_word  <= '0;
         rx_ord   <= '0;
      end else begin
         rx_valid <= 1'b0;
         if (fs_in) begin
            bit_cnt <= BC_W'(FRAME_W);
            cur_ord <= ord_next;
         end else if (bit_cnt != '0) begin
            sr      <= {sr[FRAME_W-2:0], sdi};
            bit_cnt <= bit_cnt - BC_W'(1);
            if (bit_cnt == BC_W'(1)) begin
               rx_valid <= 1'b1;
               rx_word  <= {sr[FRAME_W-2:0], sdi};
               rx_ord   <= cur_ord;
            end
         end
      end
   end

   assert_ord_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> rx_ord != '0);
   assert_tick_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fs_in && sample_tick) |=> cur_ord == ORD_W'(1));
endmodule

// File: rtl/cfi_ctrl.sv
module cfi_ctrl
   import cfi_pkg::*;
#(
   parameter int FRAME_W = 16,
   parameter int VAL_W   = 8,
   parameter int NREG    = 8,
   parameter int DC_W    = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_valid,
   input  logic [FRAME_W-1:0]      rx_word,
   input  logic [DC_W:0]           rx_ord,
   input  logic                    sample_tick,
   input  logic [FRAME_W-1:0]      adc_word,
   output logic [FRAME_W-1:0]      dac_word,
   output logic                    dac_we,
   output logic [NREG*VAL_W-1:0]   cfg_regs,
   output logic                    mixed_o,
   output logic                    slb_o
);
   localparam int ADDR_W = $clog2(NREG);
   localparam logic [VAL_W-1:0] LB_MASK = VAL_W'((1 << BIT_DLB) | (1 << BIT_SLB));

   logic [VAL_W-1:0]   regs [NREG];
   logic [DC_W-1:0]    dc;
   mode_e              mode;
   logic               claimed, is_ctrl, is_data, dlb;
   logic [ADDR_W-1:0]  wr_addr;
   logic [VAL_W-1:0]   wr_val, reg0_next;
   logic [FRAME_W-1:0] data_val;

   always_comb begin
      dc       = regs[0][DC_LSB +: DC_W];
      mode     = mode_of(regs[0][BIT_DATA], regs[0][BIT_MIXED]);
      dlb      = regs[0][BIT_DLB];
      claimed  = rx_valid && (rx_ord == ({1'b0, dc} + (DC_W+1)'(1)));
      is_ctrl  = claimed && ((mode == MODE_PGM) ||
                             (mode == MODE_MIXED && rx_word[FRAME_W-1]));
      is_data  = claimed && !is_ctrl && (mode != MODE_PGM);
      data_val = (mode == MODE_MIXED) ? {rx_word[FRAME_W-2:0], 1'b0} : rx_word;
      wr_addr  = rx_word[FRAME_W-2 -: ADDR_W];
      wr_val   = rx_word[VAL_W-1:0];
      reg0_next = (mode == MODE_MIXED) ? wr_val : (wr_val | (regs[0] & LB_MASK));
   end

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      if (g == 0) begin : g_ctrl
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (is_ctrl && wr_addr == ADDR_W'(g))
               regs[g] <= reg0_next;
         end
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               regs[g] <= '0;
            else if (is_ctrl && wr_addr == ADDR_W'(g))
               regs[g] <= wr_val;
         end
      end
      assign cfg_regs[g*VAL_W +: VAL_W] = regs[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_word <= '0;
         dac_we   <= 1'b0;
      end else if (dlb && sample_tick) begin
         dac_word <= adc_word;
         dac_we   <= 1'b1;
      end else if (is_data && !dlb) begin
         dac_word <= data_val;
         dac_we   <= 1'b1;
      end else begin
         dac_we   <= 1'b0;
      end
   end

   assign mixed_o = (mode == MODE_MIXED);
   assign slb_o   = regs[0][BIT_SLB];

   assert_plain_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_DATA) |=> (mode == MODE_DATA));
   assert_dlb_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(regs[0][BIT_DLB]) |-> $past(mode == MODE_MIXED));
   assert_slb_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(regs[0][BIT_SLB]) |-> $past(mode == MODE_MIXED));
   assert_mixed_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_we && $past(mode == MODE_MIXED && !dlb)) |-> !dac_word[0]);
   assert_dac_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dac_we |-> $past(rx_valid || sample_tick));
endmodule

// File: rtl/cfi_tx.sv
module cfi_tx #(
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_tick,
   input  logic [FRAME_W-1:0] adc_word,
   input  logic               mixed,
   input  logic               slb,
   input  logic               fs_in,
   input  logic               sdi,
   output logic               sdo,
   output logic               fs_out
);
   localparam int BC_W     = $clog2(FRAME_W + 1);
   localparam int LB_DEPTH = FRAME_W;

   logic [FRAME_W-1:0]  tx_sr;
   logic [BC_W-1:0]     tx_cnt;
   logic                fs_o;
   logic [LB_DEPTH-1:0] dl_sdi, dl_fs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         tx_cnt <= '0;
         fs_o   <= 1'b0;
      end else if (sample_tick) begin
         fs_o   <= 1'b1;
         tx_cnt <= '0;
         tx_sr  <= mixed ? {1'b0, adc_word[FRAME_W-2:0]} : adc_word;
      end else if (fs_o) begin
         fs_o   <= 1'b0;
         tx_cnt <= BC_W'(FRAME_W);
      end else if (tx_cnt != '0) begin
         tx_sr  <= {tx_sr[FRAME_W-2:0], 1'b0};
         tx_cnt <= tx_cnt - BC_W'(1);
      end
   end

   for (genvar s = 0; s < LB_DEPTH; s++) begin : g_dly
      if (s == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dl_sdi[s] <= 1'b0;
               dl_fs[s]  <= 1'b0;
            end else begin
               dl_sdi[s] <= sdi;
               dl_fs[s]  <= fs_in;
            end
         end
      end else begin : g_body
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dl_sdi[s] <= 1'b0;
               dl_fs[s]  <= 1'b0;
            end else begin
               dl_sdi[s] <= dl_sdi[s-1];
               dl_fs[s]  <= dl_fs[s-1];
            end
         end
      end
   end

   always_comb begin
      if (slb) begin
         sdo    = dl_sdi[LB_DEPTH-1];
         fs_out = dl_fs[LB_DEPTH-1];
      end else begin
         sdo    = (tx_cnt != '0) ? tx_sr[FRAME_W-1] : 1'b0;
         fs_out = fs_o;
      end
   end

   assert_mixed_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(fs_o) && $past(mixed)) |-> !tx_sr[FRAME_W-1]);
   assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!slb && fs_out) |-> !sdo);
endmodule

// File: rtl/codec_frame_interp.sv
module codec_frame_interp #(
   parameter int FRAME_W = 16,
   parameter int VAL_W   = 8,
   parameter int NREG    = 8,
   parameter int DC_W    = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fs_in,
   input  logic                  sdi,
   input  logic                  sample_tick,
   input  logic [FRAME_W-1:0]    adc_word,
   output logic                  sdo,
   output logic                  fs_out,
   output logic [FRAME_W-1:0]    dac_word,
   output logic                  dac_we,
   output logic [NREG*VAL_W-1:0] cfg_regs
);
   localparam int ADDR_W = $clog2(NREG);

   if (ADDR_W + VAL_W > FRAME_W - 1) begin : g_bad_fields
      $error("address and value fields do not fit below the flag bit");
   end
   if (VAL_W < cfi_pkg::BIT_SLB + 1 || cfi_pkg::DC_LSB + DC_W > cfi_pkg::BIT_DLB) begin : g_bad_ctrl
      $error("control register too narrow for its fields");
   end
   if (NREG < 2) begin : g_bad_nreg
      $error("need at least two registers");
   end

   logic               rx_valid, mixed, slb;
   logic [FRAME_W-1:0] rx_word;
   logic [DC_W:0]      rx_ord;

   cfi_rx #(.FRAME_W(FRAME_W), .DC_W(DC_W)) u_rx (
      .clk, .rst_n, .fs_in, .sdi, .sample_tick,
      .rx_valid, .rx_word, .rx_ord
   );

   cfi_ctrl #(.FRAME_W(FRAME_W), .VAL_W(VAL_W), .NREG(NREG), .DC_W(DC_W)) u_ctrl (
      .clk, .rst_n, .rx_valid, .rx_word, .rx_ord, .sample_tick, .adc_word,
      .dac_word, .dac_we, .cfg_regs, .mixed_o(mixed), .slb_o(slb)
   );

   cfi_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk, .rst_n, .sample_tick, .adc_word, .mixed, .slb,
      .fs_in, .sdi, .sdo, .fs_out
   );

   assert_frame_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_we && !$past(sample_tick)) |-> $past(rx_valid));
endmodule

// File: tb/codec_frame_interp_tb.sv
module codec_frame_interp_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fs_in = 1'b0;
   logic        sdi = 1'b0;
   logic        sample_tick = 1'b0;
   logic [15:0] adc_word = 16'h0;
   logic        sdo, fs_out, dac_we;
   logic [15:0] dac_word;
   logic [63:0] cfg_regs;

   int checks = 0;
   int failures = 0;
   int cur_dc = 0;

   always #4 clk = ~clk;

   codec_frame_interp u_dut (
      .clk, .rst_n, .fs_in, .sdi, .sample_tick, .adc_word,
      .sdo, .fs_out, .dac_word, .dac_we, .cfg_regs
   );

   function automatic logic [7:0] reg_of(input int i);
      return cfg_regs[i*8 +: 8];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
   endtask

   // drives one frame; returns just after the edge where its effect shows
   task automatic frame(input logic [15:0] w, input logic with_tick = 1'b0);
      @(negedge clk); fs_in = 1'b1; sdi = 1'b0; sample_tick = with_tick;
      for (int i = 15; i >= 0; i--) begin
         @(negedge clk); fs_in = 1'b0; sample_tick = 1'b0; sdi = w[i];
      end
      @(posedge clk); @(negedge clk); sdi = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic claim(input logic [15:0] w);
      tick();
      for (int k = 0; k < cur_dc; k++) frame(16'hFFFF);
      frame(w);
   endtask

   task automatic adc_out(input string req, input logic [15:0] exp_w);
      tick();
      chk(req, {sdo, fs_out}, 2'b01);
      for (int j = 15; j >= 0; j--) begin
         @(negedge clk);
         chk(req, sdo, exp_w[j]);
      end
      @(negedge clk);
      chk(req, {sdo, fs_out}, 2'b00);
   endtask

   initial begin
      #(8 * 200000);
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", cfg_regs, 64'h0);
      chk("R1", {dac_word, dac_we, sdo, fs_out}, 19'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 ADC word in program mode, MSB kept
      adc_word = 16'hA5C3;
      adc_out("R7", 16'hA5C3);

      // R4 program-mode writes to every non-control register, bit 15 ignored
      for (int a = 1; a < 8; a++)
         claim(16'((a % 2) << 15) | 16'(a << 12) | 16'((a * 37 + 11) & 8'hFF));
      for (int a = 1; a < 8; a++)
         chk("R4", reg_of(a), (a * 37 + 11) & 8'hFF);
      chk("R2", dac_we, 1'b0);

      // R4 mode 10 is still program mode
      claim(16'h0002);
      claim(16'h6077);
      chk("R4", reg_of(6), 8'h77);
      chk("R4", reg_of(0), 8'h02);
      claim(16'h0000);

      // R3 cascade position sweep
      for (int d = 0; d < 4; d++) begin
         claim(16'(d << 2));
         cur_dc = d;
         chk("R3", reg_of(0), 8'(d << 2));
         tick();
         for (int o = 1; o <= d + 3; o++)
            frame(16'h7000 | 16'(o << 4) | 16'(d));
         chk("R3", reg_of(7), 8'(((d + 1) << 4) | d));
      end
      // R3 tick coincident with frame sync: that frame is number 1
      claim(16'h0004);
      cur_dc = 1;
      frame(16'h7011, 1'b1);
      frame(16'h7022);
      chk("R3", reg_of(7), 8'h22);
      claim(16'h0000);
      cur_dc = 0;

      // R10 program-mode write cannot clear a loop-back bit
      claim(16'h0020);
      claim(16'h0000);
      chk("R10", reg_of(0), 8'h20);
      claim(16'h0023);
      chk("R10", reg_of(0), 8'h23);

      // R9 digital loop-back
      adc_word = 16'h1234;
      tick();
      chk("R9", {dac_we, dac_word}, {1'b1, 16'h1234});
      adc_word = 16'h5555;
      frame(16'h0ABC);
      chk("R9", {dac_we, dac_word}, {1'b0, 16'h1234});
      claim(16'h8003);
      chk("R10", reg_of(0), 8'h03);

      // R6 mixed data sweep and mixed control write
      for (int i = 0; i < 8; i++) begin
         logic [15:0] w;
         w = 16'((i * 16'h1357) ^ 16'h2468) & 16'h7FFF;
         claim(w);
         chk("R6", {dac_we, dac_word}, {1'b1, w[14:0], 1'b0});
      end
      claim(16'hD03C);
      chk("R6", reg_of(5), 8'h3C);
      chk("R6", dac_we, 1'b0);

      // R7 mixed mode clears outgoing MSB
      adc_word = 16'hF00F;
      adc_out("R7", 16'h700F);

      // R8 serial loop-back
      claim(16'h8043);
      chk("R8", reg_of(0), 8'h43);
      begin
         logic [47:0] pat, fsp;
         for (int i = 0; i < 48; i++) begin
            pat[i] = ((i * 7) % 5 < 2) && i != 1 && i != 21;
            fsp[i] = (i == 0 || i == 20);
         end
         for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (i >= 16) begin
               chk("R8", sdo, pat[i-16]);
               chk("R8", fs_out, fsp[i-16]);
            end
            fs_in = fsp[i];
            sdi = pat[i];
         end
         @(negedge clk); fs_in = 1'b0; sdi = 1'b0;
         repeat (20) @(negedge clk);
      end
      claim(16'h8003);
      chk("R10", reg_of(0), 8'h03);

      // R5 plain data mode
      claim(16'h8001);
      chk("R5", reg_of(0), 8'h01);
      claim(16'hBEEF);
      chk("R5", {dac_we, dac_word}, {1'b1, 16'hBEEF});
      claim(16'hF0AA);
      chk("R5", {dac_we, dac_word}, {1'b1, 16'hF0AA});
      chk("R5", reg_of(7), 8'h22);
      chk("R5", reg_of(0), 8'h01);
      claim(16'h8003);
      chk("R5", reg_of(0), 8'h01);

      // R1 and R5: only reset leaves plain data mode
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R1", cfg_regs, 64'h0);
      chk("R1", {dac_word, dac_we}, 17'h0);
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule